// File: doc/BRIEF.md
# Four-Way External Bus Token Arbiter

This block lets four processors share one external bus. Each processor pulls its own request line low when it needs the bus. For each processor the arbiter drives one active-low "bus held elsewhere" line. While that line is low, the processor stays a slave. When the arbiter raises it, the processor becomes the bus owner. During reset and for a short settling window afterwards, all four lines are held low. This way every processor starts out as a slave, and no processor drives the bus while the others are still synchronizing.

Ownership works as a token. The token moves only when the current owner has dropped its request and some other processor is asking for the bus. If nobody else asks, the token stays parked with the last owner. A single mode input chooses how simultaneous requesters are ranked. In fixed mode, the lowest-numbered processor wins. In rotating mode, the search starts just after the current owner and wraps around.

Top module: `bus_token_arbiter`

## Requirements
- R1: At most one bit of `yield_n` is high at any time, and a high bit marks the current bus owner.
- R2: While `rst_n` is low, `yield_n` is all zeros regardless of `req_n` and `rotate`.
- R3: After `rst_n` rises, the first INIT_CYCLES (default 2) rising clock edges ignore `req_n`, and `yield_n` stays all zeros through them.
- R4: After the init window, the token rests at processor 1 (bit 0), but `yield_n` stays all zeros until some processor requests.
- R5: When the bus is free, a requester's `yield_n` bit goes high right after the first rising edge at which its `req_n` bit is sampled low.
- R6: While the owner's `req_n` bit is low, no other bit of `yield_n` rises and the owner's bit stays high.
- R7: When no processor other than the owner is requesting, `yield_n` keeps its value, including after the owner releases its request.
- R8: With `rotate` = 0, the lowest-indexed pending requester (bit 0 = processor 1) wins the freed bus.
- R9: With `rotate` = 1, the freed bus goes to the first pending requester at index owner+1, owner+2, … modulo 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rotate | input | 1 | 0 = fixed priority, 1 = rotating priority |
| req_n | input | 4 | Active-low bus requests, bit i = processor i+1 |
| yield_n | output | 4 | Active-low "bus held by another"; high bit = owner |

## Verification
Every result is registered exactly once. A grant, a handover or a parked hold therefore shows on `yield_n` right after the rising edge that samples the request pattern. The only exception is reset, which clears the outputs at once without waiting for an edge. The bench drives each pattern at a falling edge, lets one rising edge pass, and compares at the following falling edge. During the init window it does this edge by edge, so a grant that arrives one edge early or late is reported.

// File: rtl/bus_token_arbiter.sv
module bus_token_arbiter #(
  parameter int NPROC       = 4,
  parameter int INIT_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rotate,
  input  logic [NPROC-1:0] req_n,
  output logic [NPROC-1:0] yield_n
);
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1;
  localparam int CW = $clog2(INIT_CYCLES + 2);

  logic [CW-1:0]    init_cnt;
  logic             ready;
  logic [IW-1:0]    owner;
  logic             granted;
  logic [NPROC-1:0] want;
  logic             owner_busy;
  logic             found;
  logic [IW-1:0]    pick;

  assign ready      = (init_cnt == CW'(INIT_CYCLES));
  assign want       = ~req_n;
  assign owner_busy = granted && want[owner];

  function automatic logic [IW-1:0] slot(input logic rot, input logic [IW-1:0] own, input int k);
    int raw;
    raw = rot ? (int'(own) + 1 + k) % NPROC : k;
    return IW'(raw);
  endfunction

  always_comb begin
    found = 1'b0;
    pick  = owner;
    for (int k = 0; k < NPROC; k++) begin
      if (!found && want[slot(rotate, owner, k)]) begin
        found = 1'b1;
        pick  = slot(rotate, owner, k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
      owner    <= '0;
      granted  <= 1'b0;
    end else if (!ready) begin
      init_cnt <= init_cnt + 1'b1;
    end else if (!owner_busy && found) begin
      owner   <= pick;
      granted <= 1'b1;
    end
  end

  always_comb begin
    yield_n = '0;
    if (granted) yield_n[owner] = 1'b1;
  end

  a_r1_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(yield_n));

  a_r3_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (yield_n == '0));

  a_r6_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (|(yield_n & ~req_n)) |=> $stable(yield_n));

  a_r7_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (&req_n) |=> $stable(yield_n));

  a_r5_grant_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    (|(yield_n & ~$past(yield_n))) |-> (|(yield_n & ~$past(req_n))));
endmodule

// File: tb/test_bus_token_arbiter.sv
module test_bus_token_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rotate = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic [3:0] yield_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_token_arbiter i_bus_token_arbiter (
    .clk(clk), .rst_n(rst_n), .rotate(rotate), .req_n(req_n), .yield_n(yield_n)
  );

  // row = {tag, rotate, req_n, expected yield_n}; applied after reset + idle init
  localparam int NV = 21;
  localparam logic [12:0] VEC [NV] = '{
    {4'd4, 1'b0, 4'b1111, 4'b0000},  // R4 parked, nothing granted
    {4'd5, 1'b0, 4'b1110, 4'b0001},  // R5 P1 granted
    {4'd6, 1'b0, 4'b1110, 4'b0001},  // R6 held
    {4'd6, 1'b0, 4'b0100, 4'b0001},  // R6 R1 others wait
    {4'd8, 1'b0, 4'b0101, 4'b0010},  // R8 fixed: P2 over P4
    {4'd6, 1'b0, 4'b0101, 4'b0010},  // R6
    {4'd8, 1'b0, 4'b0111, 4'b1000},  // R8 P4 gets it
    {4'd7, 1'b0, 4'b1111, 4'b1000},  // R7 parked
    {4'd7, 1'b0, 4'b1111, 4'b1000},  // R7
    {4'd5, 1'b1, 4'b1011, 4'b0100},  // R5 P3
    {4'd6, 1'b1, 4'b1010, 4'b0100},  // R6
    {4'd6, 1'b1, 4'b0000, 4'b0100},  // R6 all pending
    {4'd9, 1'b1, 4'b0100, 4'b1000},  // R9 after P3 -> P4
    {4'd9, 1'b1, 4'b1100, 4'b0001},  // R9 wrap -> P1
    {4'd9, 1'b1, 4'b1101, 4'b0010},  // R9 P2
    {4'd9, 1'b1, 4'b0110, 4'b1000},  // R9 P4 over P1
    {4'd8, 1'b0, 4'b1110, 4'b0001},  // R8 P1
    {4'd8, 1'b0, 4'b0101, 4'b0010},  // R8 P2 over P4
    {4'd6, 1'b0, 4'b1101, 4'b0010},  // R6
    {4'd7, 1'b0, 4'b1111, 4'b0010},  // R7
    {4'd7, 1'b0, 4'b1101, 4'b0010}   // R7 owner re-requests
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: yield_n=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    // R2: reset with every processor requesting
    req_n = 4'b0000;
    repeat (3) edge_step();
    check("R2", yield_n, 4'b0000);
    rst_n = 1'b1;
    edge_step();
    check("R3 edge1", yield_n, 4'b0000);
    edge_step();
    check("R3 edge2", yield_n, 4'b0000);
    edge_step();
    check("R5 first grant after init", yield_n, 4'b0001);
    // R2: asynchronous reset mid-ownership
    #1 rst_n = 1'b0;
    #1 check("R2 async", yield_n, 4'b0000);
    @(negedge clk);
    req_n = 4'hF;
    rotate = 1'b0;
    edge_step();
    rst_n = 1'b1;
    edge_step();
    edge_step();
    check("R3 idle init", yield_n, 4'b0000);
    for (int i = 0; i < NV; i++) begin
      rotate = VEC[i][8];
      req_n  = VEC[i][7:4];
      edge_step();
      check($sformatf("R%0d row%0d", VEC[i][12:9], i), yield_n, VEC[i][3:0]);
    end
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end
endmodule